// File: doc/BRIEF.md
# RTC Alarm Match Unit

This block watches the running calendar and time fields produced by a separate timekeeping counter and raises a sticky alarm flag when the current time agrees with a programmed alarm. Six alarm bytes cover seconds, minutes, hours, day of month, month and weekday. Each byte carries its own enable in the top bit and a compare value in the lower seven bits, in the same BCD layout as the matching time field. Year and sub-second values have no alarm byte.

The comparison runs only on the one-cycle `tick` strobe that the timekeeping counter issues each time its fields change. The match condition is: at least one field is enabled, and every enabled field equals its time field. When it holds on a tick, the flag is set and stays set. Software clears the flag by writing a zero to its status bit. When the auto-clear option is configured, reading the status byte clears the flag and returns the value it had before the read. The `alarm_out` level follows the flag, so it can drive an interrupt line.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, all six alarm bytes, the configuration byte and the alarm flag are zero, and `alarm_out` is low.
- R2: The alarm bytes sit at addresses 0x0C to 0x11 in the order seconds, minutes, hours, date, month, weekday. Each is fully writable and reads back unchanged. The configuration byte at 0x0B holds only bit 7 (auto-clear), and its other bits read as 0. Any unmapped address reads 0x00. Read data appears on `reg_rdata` one cycle after the `reg_rd` strobe.
- R3: Bit 7 of an alarm byte enables that field. Bits 6:0 are compared with the 7-bit time field of the same index (field i is `cur_time[7*i +: 7]`, with i=0 for seconds and i=5 for weekday). A match requires equality on every enabled field and ignores disabled fields. Any one field, any combination of fields, or all six may be enabled.
- R4: When no alarm byte has its enable bit set, the flag is never set, whatever the values.
- R5: The flag is set at the clock edge where `tick` is high and the match holds, so it is visible in the next cycle. A match without `tick` never sets it.
- R6: Writing the status byte (address 0x0A) with bit 0 equal to 0 clears the flag. Writing bit 0 as 1 neither sets nor clears it.
- R7: Reading the status byte while the auto-clear bit is 1 clears the flag, and the read data returns the value from before the clear. With auto-clear at 0, a status read leaves the flag unchanged.
- R8: A set caused by a tick takes priority over a write clear or a read clear in the same cycle.
- R9: `alarm_out` is high exactly while the alarm flag is 1.
- R10: A status read returns the flag in bit 0, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe when the time fields update |
| cur_time | input | 42 | Six 7-bit BCD time fields, seconds in the lowest bits |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid one cycle after `reg_rd` |
| alarm_out | output | 1 | Alarm level, high while the flag is set |

## Verification
The bound checker checks the following on every cycle:
- a matching tick always sets the flag, and the flag never rises without one;
- a raised match signal always agrees with the enabled fields, and no match is raised with no fields enabled;
- write clears and read clears take effect when no tick competes in the same cycle;
- the status read value is correctly padded with zeros.

The directed scenarios are needed for the rest:
- the register address map and readback;
- that a disabled field with a differing value really is ignored;
- that a held match stays silent without a tick;
- the exact pre-clear value returned by a clearing read;
- the priority of a set over a clear arriving in the same cycle.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int STATUS_ADDR = 10;
    localparam int CFG_ADDR    = 11;
    localparam int ALARM_BASE  = 12;
    localparam int ALM_BIT     = 0;
    localparam int ARST_BIT    = 7;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int NUM_FIELDS = 6,
    parameter int FIELD_W    = 8,
    parameter int ADDR_W     = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [FIELD_W-1:0]            wr_data,
    output logic [NUM_FIELDS*FIELD_W-1:0] alarm_flat,
    output logic                          auto_clr
);
    typedef struct packed {
        logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm;
        logic                               arst;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(CFG_ADDR)) begin
                st_d.arst = wr_data[ARST_BIT];
            end
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (wr_addr == ADDR_W'(ALARM_BASE + i)) begin
                    st_d.alarm[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_flat = st_q.alarm;
    assign auto_clr   = st_q.arst;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int NUM_FIELDS = 6,
    parameter int FIELD_W    = 8
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0]     alarm_flat,
    input  logic [NUM_FIELDS*(FIELD_W-1)-1:0] cur_time,
    output logic                              hit
);
    localparam int VAL_W = FIELD_W - 1;

    logic [NUM_FIELDS-1:0] field_en;
    logic [NUM_FIELDS-1:0] field_ok;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        logic [VAL_W-1:0] want;
        logic [VAL_W-1:0] have;
        assign want        = alarm_flat[g*FIELD_W +: VAL_W];
        assign have        = cur_time[g*VAL_W +: VAL_W];
        assign field_en[g] = alarm_flat[g*FIELD_W + VAL_W];
        assign field_ok[g] = !field_en[g] || (want == have);
    end

    assign hit = (|field_en) && (&field_ok);
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic clr_req,
    input  logic rd_status,
    input  logic auto_clr,
    output logic alm
);
    typedef struct packed {
        logic alm;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_req || (rd_status && auto_clr)) begin
            st_d.alm = 1'b0;
        end
        if (tick && hit) begin
            st_d.alm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alm = st_q.alm;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int NUM_FIELDS = 6,
    parameter int FIELD_W    = 8,
    parameter int ADDR_W     = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick,
    input  logic [NUM_FIELDS*(FIELD_W-1)-1:0] cur_time,
    input  logic                              reg_wr,
    input  logic                              reg_rd,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [FIELD_W-1:0]                reg_wdata,
    output logic [FIELD_W-1:0]                reg_rdata,
    output logic                              alarm_out
);
    typedef struct packed {
        logic [FIELD_W-1:0] rdata;
    } rd_t;

    logic [NUM_FIELDS*FIELD_W-1:0] alarm_flat;
    logic                          auto_clr;
    logic                          hit;
    logic                          alm_q;
    logic                          clr_req;
    logic                          rd_status;
    rd_t                           rd_d, rd_q;

    assign clr_req   = reg_wr && (reg_addr == ADDR_W'(STATUS_ADDR)) && !reg_wdata[ALM_BIT];
    assign rd_status = reg_rd && (reg_addr == ADDR_W'(STATUS_ADDR));

    rtc_alarm_regs #(
        .NUM_FIELDS(NUM_FIELDS),
        .FIELD_W   (FIELD_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .alarm_flat(alarm_flat),
        .auto_clr  (auto_clr)
    );

    rtc_alarm_cmp #(
        .NUM_FIELDS(NUM_FIELDS),
        .FIELD_W   (FIELD_W)
    ) u_cmp (
        .alarm_flat(alarm_flat),
        .cur_time  (cur_time),
        .hit       (hit)
    );

    rtc_alarm_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hit      (hit),
        .clr_req  (clr_req),
        .rd_status(rd_status),
        .auto_clr (auto_clr),
        .alm      (alm_q)
    );

    always_comb begin
        rd_d = rd_q;
        if (reg_rd) begin
            rd_d.rdata = '0;
            if (reg_addr == ADDR_W'(STATUS_ADDR)) begin
                rd_d.rdata[ALM_BIT] = alm_q;
            end
            if (reg_addr == ADDR_W'(CFG_ADDR)) begin
                rd_d.rdata[ARST_BIT] = auto_clr;
            end
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (reg_addr == ADDR_W'(ALARM_BASE + i)) begin
                    rd_d.rdata = alarm_flat[i*FIELD_W +: FIELD_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign reg_rdata = rd_q.rdata;
    assign alarm_out = alm_q;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
    import rtc_alarm_pkg::*;
#(
    parameter int NUM_FIELDS = 6,
    parameter int FIELD_W    = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              tick,
    input logic                              hit,
    input logic                              clr_req,
    input logic                              rd_status,
    input logic                              auto_clr,
    input logic                              alarm_out,
    input logic [FIELD_W-1:0]                reg_rdata,
    input logic [NUM_FIELDS*FIELD_W-1:0]     alarm_flat,
    input logic [NUM_FIELDS*(FIELD_W-1)-1:0] cur_time
);
    localparam int VAL_W = FIELD_W - 1;
    localparam logic [FIELD_W-1:0] PAD_MASK = ~(FIELD_W'(1) << ALM_BIT);

    logic any_en;
    logic agree;

    always_comb begin
        any_en = 1'b0;
        agree  = 1'b1;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (alarm_flat[i*FIELD_W + VAL_W]) begin
                any_en = 1'b1;
                if (alarm_flat[i*FIELD_W +: VAL_W] != cur_time[i*VAL_W +: VAL_W]) begin
                    agree = 1'b0;
                end
            end
        end
    end

    AST_HIT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> agree); // R3

    AST_NO_ENABLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |-> !hit); // R4

    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit) |=> alarm_out); // R5

    AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_out && !(tick && hit)) |=> !alarm_out); // R5

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(tick && hit)) |=> !alarm_out); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && auto_clr && !(tick && hit))
        |=> (!alarm_out && reg_rdata[ALM_BIT] == $past(alarm_out))); // R7

    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !auto_clr && !clr_req && alarm_out) |=> alarm_out); // R7

    AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> ((reg_rdata & PAD_MASK) == '0)); // R10
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(
    .NUM_FIELDS(NUM_FIELDS),
    .FIELD_W   (FIELD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hit       (hit),
    .clr_req   (clr_req),
    .rd_status (rd_status),
    .auto_clr  (auto_clr),
    .alarm_out (alarm_out),
    .reg_rdata (reg_rdata),
    .alarm_flat(alarm_flat),
    .cur_time  (cur_time)
);

// File: tb/rtc_alarm_match_test.sv
module rtc_alarm_match_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [41:0] cur_time = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        alarm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_alarm_match uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cur_time(cur_time),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_out(alarm_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic set_now(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                           input logic [6:0] dt, input logic [6:0] mo, input logic [6:0] w);
        cur_time = {w, mo, dt, h, m, s};
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 6; i++) wr(5'(12 + i), 8'h00);
        wr(5'h0B, 8'h00);
        wr(5'h0A, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 alarm_out after reset", {7'b0, alarm_out}, 8'h00);
        for (int i = 0; i < 6; i++) begin
            rd(5'(12 + i), d);
            check("R1 alarm byte reset", d, 8'h00);
        end
        rd(5'h0B, d);
        check("R1 config reset", d, 8'h00);
        rd(5'h0A, d);
        check("R1 status reset", d, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        for (int i = 0; i < 6; i++) wr(5'(12 + i), 8'(8'h5A ^ (i * 8'h13)));
        for (int i = 0; i < 6; i++) begin
            rd(5'(12 + i), d);
            check("R2 alarm byte readback", d, 8'(8'h5A ^ (i * 8'h13)));
        end
        wr(5'h0B, 8'hFF);
        rd(5'h0B, d);
        check("R2 config readback", d, 8'h80);
        rd(5'h03, d);
        check("R2 unmapped read", d, 8'h00);
        rd(5'h1F, d);
        check("R2 unmapped high read", d, 8'h00);
        clear_all();
        check("R2 no alarm from register writes", {7'b0, alarm_out}, 8'h00);
    endtask

    task automatic t_single();
        logic [7:0] d;
        wr(5'h0C, 8'h59);
        wr(5'h0D, 8'hB0);
        set_now(7'h45, 7'h30, 7'h12, 7'h15, 7'h06, 7'h03);
        pulse_tick();
        check("R3 minute-only match with disabled differing seconds", {7'b0, alarm_out}, 8'h01);
        rd(5'h0A, d);
        check("R9 status bit agrees with alarm_out", d, {7'b0, alarm_out});
        check("R10 status read value", d, 8'h01);
        wr(5'h0A, 8'h00);
        check("R6 write zero clears", {7'b0, alarm_out}, 8'h00);
        set_now(7'h45, 7'h31, 7'h12, 7'h15, 7'h06, 7'h03);
        pulse_tick();
        check("R3 minute mismatch", {7'b0, alarm_out}, 8'h00);
        clear_all();
    endtask

    task automatic t_combo();
        wr(5'h0E, 8'h92);
        wr(5'h11, 8'h83);
        set_now(7'h00, 7'h00, 7'h12, 7'h01, 7'h01, 7'h04);
        pulse_tick();
        check("R3 hour match weekday mismatch", {7'b0, alarm_out}, 8'h00);
        set_now(7'h00, 7'h00, 7'h12, 7'h01, 7'h01, 7'h03);
        pulse_tick();
        check("R3 hour and weekday match", {7'b0, alarm_out}, 8'h01);
        clear_all();
        wr(5'h0C, 8'hC5); wr(5'h0D, 8'hB0); wr(5'h0E, 8'h92);
        wr(5'h0F, 8'h95); wr(5'h10, 8'h86); wr(5'h11, 8'h83);
        set_now(7'h45, 7'h30, 7'h12, 7'h15, 7'h06, 7'h02);
        pulse_tick();
        check("R3 all fields, weekday off", {7'b0, alarm_out}, 8'h00);
        set_now(7'h45, 7'h30, 7'h12, 7'h15, 7'h06, 7'h03);
        pulse_tick();
        check("R3 all fields match", {7'b0, alarm_out}, 8'h01);
        clear_all();
    endtask

    task automatic t_none();
        wr(5'h0C, 8'h45); wr(5'h0D, 8'h30); wr(5'h0E, 8'h12);
        wr(5'h0F, 8'h15); wr(5'h10, 8'h06); wr(5'h11, 8'h03);
        set_now(7'h45, 7'h30, 7'h12, 7'h15, 7'h06, 7'h03);
        pulse_tick();
        pulse_tick();
        check("R4 no enabled field never fires", {7'b0, alarm_out}, 8'h00);
        clear_all();
    endtask

    task automatic t_tick();
        wr(5'h0C, 8'hC5);
        set_now(7'h45, 7'h00, 7'h00, 7'h01, 7'h01, 7'h01);
        repeat (4) @(negedge clk);
        check("R5 match without tick does not set", {7'b0, alarm_out}, 8'h00);
        pulse_tick();
        check("R5 tick with match sets", {7'b0, alarm_out}, 8'h01);
        wr(5'h0A, 8'h00);
        repeat (3) @(negedge clk);
        check("R5 held match stays clear without tick", {7'b0, alarm_out}, 8'h00);
        clear_all();
    endtask

    task automatic t_write_one();
        wr(5'h0A, 8'hFF);
        check("R6 writing one does not set", {7'b0, alarm_out}, 8'h00);
        wr(5'h0D, 8'h80);
        set_now(7'h00, 7'h00, 7'h00, 7'h01, 7'h01, 7'h01);
        pulse_tick();
        wr(5'h0A, 8'h01);
        check("R6 writing one does not clear", {7'b0, alarm_out}, 8'h01);
        clear_all();
    endtask

    task automatic t_read_clear();
        logic [7:0] d;
        wr(5'h0B, 8'h80);
        wr(5'h0D, 8'h80);
        set_now(7'h00, 7'h00, 7'h00, 7'h01, 7'h01, 7'h01);
        pulse_tick();
        rd(5'h0A, d);
        check("R7 clearing read returns pre-clear value", d, 8'h01);
        check("R7 auto-clear read clears", {7'b0, alarm_out}, 8'h00);
        rd(5'h0A, d);
        check("R7 second read sees cleared flag", d, 8'h00);
        wr(5'h0B, 8'h00);
        pulse_tick();
        rd(5'h0A, d);
        check("R7 read without auto-clear returns flag", d, 8'h01);
        check("R7 read without auto-clear keeps flag", {7'b0, alarm_out}, 8'h01);
        clear_all();
    endtask

    task automatic t_priority();
        wr(5'h0D, 8'h80);
        set_now(7'h00, 7'h00, 7'h00, 7'h01, 7'h01, 7'h01);
        tick = 1'b1; reg_wr = 1'b1; reg_addr = 5'h0A; reg_wdata = 8'h00;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        check("R8 set beats write clear", {7'b0, alarm_out}, 8'h01);
        wr(5'h0B, 8'h80);
        tick = 1'b1; reg_rd = 1'b1; reg_addr = 5'h0A;
        @(negedge clk);
        tick = 1'b0; reg_rd = 1'b0;
        check("R8 set beats read clear", {7'b0, alarm_out}, 8'h01);
        check("R9 alarm_out high while flag set", {7'b0, alarm_out}, 8'h01);
        clear_all();
        check("R9 alarm_out low after clear", {7'b0, alarm_out}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_single();
        t_combo();
        t_none();
        t_tick();
        t_write_one();
        t_read_clear();
        t_priority();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule